// File: doc/BRIEF.md
# Three-Input Function-Coded ALU

This unit combines three operand words, A, B and C, under the control of an 8-bit function code. In Boolean mode every code bit stands for one of the eight input combinations a result bit can see. Each result bit is 1 when the code bit selected by its own (C, B, A) triple is set, so any of the 256 three-input Boolean functions can be selected with a single code. In arithmetic mode two further 8-bit subfunction codes, written in the same encoding, describe two functions of B and C. The unit adds the first one, masked by A, to the second one.

In both modes a carry-select input can add nothing, a constant 1 or an external carry-in to the result. A strobe on `in_valid` captures the result and the carry out of bit WIDTH-1 into output registers. `out_valid` then pulses for the following cycle. The registered result stays unchanged until the next strobe.

Top module: `tri_fn_alu`

## Requirements
- R1: After a synchronous reset, `out_valid`, `result` and `carry_out` are all 0.
- R2: In Boolean mode (`arith_mode`=0), result bit i equals `fn_code[4*C[i] + 2*B[i] + A[i]]`. For example, code 0x01 selects the bits where A, B and C are all 0, and code 0x80 selects the bits where all three are 1.
- R3: Every one of the 256 Boolean function codes gives the truth-table result that R2 defines, before any carry is added.
- R4: The carry-select value 01 adds 1 to the result in either mode. `carry_out` is the carry out of bit WIDTH-1 of that addition, so code 0xFF with +1 gives a result of 0 and a `carry_out` of 1.
- R5: The carry-select value 10 adds `carry_in`. The values 00 and 11 add nothing, and in those cases `carry_in` has no effect.
- R6: In arithmetic mode (`arith_mode`=1), the result is `(A & f1) + f2` plus the selected carry.
  - f1 bit i is `sub1_code[2*(2*C[i]+B[i])+1]`, and f2 bit i uses `sub2_code` in the same way.
  - Code 0xCC therefore means B, 0x33 means ~B, 0xF0 means C, 0xFF means all ones and 0x00 means zero.
- R7: In arithmetic mode, `carry_out` is the carry out of bit WIDTH-1 of the full three-term sum.
- R8: `result` and `carry_out` update, and `out_valid` is 1, in the cycle after each `in_valid` strobe. Strobes on consecutive cycles give consecutive results. `out_valid` is 0 in the cycle after a cycle without a strobe.
- R9: In a cycle without `in_valid`, changes on the operand, code or carry inputs leave `result` and `carry_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture strobe for the current inputs |
| arith_mode | input | 1 | 0: Boolean truth table, 1: masked sum of subfunctions |
| fn_code | input | 8 | Boolean truth-table code |
| sub1_code | input | 8 | Code of the subfunction that is masked by A |
| sub2_code | input | 8 | Code of the added subfunction |
| carry_sel | input | 2 | 00 none, 01 +1, 10 +carry_in, 11 none |
| carry_in | input | 1 | External carry for carry_sel = 10 |
| op_a | input | WIDTH | Operand A |
| op_b | input | WIDTH | Operand B |
| op_c | input | WIDTH | Operand C |
| out_valid | output | 1 | One-cycle pulse after each strobe |
| result | output | WIDTH | Registered result |
| carry_out | output | 1 | Registered carry out of bit WIDTH-1 |

## Verification
Two things can happen in the same cycle: a Boolean truth-table result that is all ones, and a carry injection that wraps it to zero. The bench provokes this by using code 0xFF with the +1 and +carry-in selects. It checks that the result is zero and that `carry_out` rises in that one output cycle. The bench also issues strobes on consecutive cycles while changing the mode between them. Each new result must replace the previous one with `out_valid` held high. A reference model, clocked on the same edge, must match the outputs in every cycle.

// File: rtl/tri_fn_alu_pkg.sv
package tri_fn_alu_pkg;

  localparam int CODE_W = 8;
  localparam int SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    CSEL_NONE = 2'b00,
    CSEL_ONE  = 2'b01,
    CSEL_CIN  = 2'b10,
    CSEL_RSVD = 2'b11
  } csel_e;

  typedef logic [CODE_W-1:0] fcode_t;

endpackage

// File: rtl/tri_fn_minterm.sv
module tri_fn_minterm #(
  parameter int WIDTH = 32
) (
  input  tri_fn_alu_pkg::fcode_t code,
  input  logic [WIDTH-1:0]       in_a,
  input  logic [WIDTH-1:0]       in_b,
  input  logic [WIDTH-1:0]       in_c,
  output logic [WIDTH-1:0]       out_bits
);

  // One 8:1 selector per bit: the code is a truth table indexed by {c,b,a}.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [2:0] idx;
    assign idx         = {in_c[i], in_b[i], in_a[i]};
    assign out_bits[i] = code[idx];
  end

endmodule

// File: rtl/tri_fn_carry_sel.sv
module tri_fn_carry_sel (
  input  logic [tri_fn_alu_pkg::SEL_W-1:0] sel,
  input  logic                             cin,
  output logic                             inc
);
  import tri_fn_alu_pkg::*;

  csel_e mode;
  assign mode = csel_e'(sel);

  always_comb begin
    unique case (mode)
      CSEL_ONE: inc = 1'b1;
      CSEL_CIN: inc = cin;
      default:  inc = 1'b0;
    endcase
  end

endmodule

// File: rtl/tri_fn_adder.sv
module tri_fn_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             inc,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int EXT_W = WIDTH + 1;

  logic [EXT_W-1:0] total;

  assign total = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, inc};
  assign sum   = total[WIDTH-1:0];
  assign cout  = total[WIDTH];

endmodule

// File: rtl/tri_fn_alu.sv
module tri_fn_alu #(
  parameter int WIDTH = 32
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 in_valid,
  input  logic                                 arith_mode,
  input  logic [tri_fn_alu_pkg::CODE_W-1:0]    fn_code,
  input  logic [tri_fn_alu_pkg::CODE_W-1:0]    sub1_code,
  input  logic [tri_fn_alu_pkg::CODE_W-1:0]    sub2_code,
  input  logic [tri_fn_alu_pkg::SEL_W-1:0]     carry_sel,
  input  logic                                 carry_in,
  input  logic [WIDTH-1:0]                     op_a,
  input  logic [WIDTH-1:0]                     op_b,
  input  logic [WIDTH-1:0]                     op_c,
  output logic                                 out_valid,
  output logic [WIDTH-1:0]                     result,
  output logic                                 carry_out
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] bool_bits;
  logic [WIDTH-1:0] sub1_bits;
  logic [WIDTH-1:0] sub2_bits;
  logic [WIDTH-1:0] add_x;
  logic [WIDTH-1:0] add_y;
  logic [WIDTH-1:0] sum_w;
  logic             inc_w;
  logic             cout_w;

  // Boolean truth table over A, B, C.
  tri_fn_minterm #(.WIDTH(WIDTH)) u_bool (
    .code(fn_code), .in_a(op_a), .in_b(op_b), .in_c(op_c), .out_bits(bool_bits)
  );

  // Subfunctions of B and C: A is held at ones so only odd code bits matter.
  tri_fn_minterm #(.WIDTH(WIDTH)) u_sub1 (
    .code(sub1_code), .in_a(ALL_ONES), .in_b(op_b), .in_c(op_c), .out_bits(sub1_bits)
  );

  tri_fn_minterm #(.WIDTH(WIDTH)) u_sub2 (
    .code(sub2_code), .in_a(ALL_ONES), .in_b(op_b), .in_c(op_c), .out_bits(sub2_bits)
  );

  tri_fn_carry_sel u_csel (
    .sel(carry_sel), .cin(carry_in), .inc(inc_w)
  );

  always_comb begin
    if (arith_mode) begin
      add_x = op_a & sub1_bits;
      add_y = sub2_bits;
    end else begin
      add_x = bool_bits;
      add_y = '0;
    end
  end

  tri_fn_adder #(.WIDTH(WIDTH)) u_add (
    .x(add_x), .y(add_y), .inc(inc_w), .sum(sum_w), .cout(cout_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      carry_out <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= sum_w;
        carry_out <= cout_w;
      end
    end
  end

endmodule

// File: rtl/tri_fn_alu_chk.sv
module tri_fn_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             arith_mode,
  input logic [7:0]       fn_code,
  input logic [7:0]       sub1_code,
  input logic [7:0]       sub2_code,
  input logic [1:0]       carry_sel,
  input logic [WIDTH-1:0] op_b,
  input logic             out_valid,
  input logic [WIDTH-1:0] result,
  input logic             carry_out
);

  // R8: a strobe yields a valid output next cycle
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R8: no strobe, no valid pulse
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R9: outputs hold without a strobe
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(carry_out)));

  // R2: the all-zero truth table gives zero
  a_r2_zero_code: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !arith_mode && fn_code == 8'h00 && carry_sel == 2'b00)
      |=> (result == '0 && !carry_out));

  // R4: all ones plus one wraps with a carry
  a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !arith_mode && fn_code == 8'hFF && carry_sel == 2'b01)
      |=> (result == '0 && carry_out));

  // R6: zero masked term plus B gives B
  a_r6_pass_b: assert property (@(posedge clk) disable iff (rst)
    (in_valid && arith_mode && sub1_code == 8'h00 && sub2_code == 8'hCC && carry_sel == 2'b00)
      |=> (result == $past(op_b) && !carry_out));

endmodule

bind tri_fn_alu tri_fn_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .arith_mode(arith_mode),
  .fn_code(fn_code), .sub1_code(sub1_code), .sub2_code(sub2_code),
  .carry_sel(carry_sel), .op_b(op_b), .out_valid(out_valid),
  .result(result), .carry_out(carry_out)
);

// File: tb/tri_fn_alu_test.sv
`timescale 1ns/1ps
module tri_fn_alu_test;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         arith_mode = 1'b0;
  logic [7:0]   fn_code = '0, sub1_code = '0, sub2_code = '0;
  logic [1:0]   carry_sel = '0;
  logic         carry_in = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0, op_c = '0;
  logic         out_valid;
  logic [W-1:0] result;
  logic         carry_out;

  int checks = 0;
  int fails  = 0;
  string cur_tag = "R1";
  bit running = 1'b0;

  always #10 clk = ~clk;

  tri_fn_alu #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .arith_mode(arith_mode),
    .fn_code(fn_code), .sub1_code(sub1_code), .sub2_code(sub2_code),
    .carry_sel(carry_sel), .carry_in(carry_in),
    .op_a(op_a), .op_b(op_b), .op_c(op_c),
    .out_valid(out_valid), .result(result), .carry_out(carry_out)
  );

  // Behavioural reference: bit-by-bit truth table lookup and a wide integer sum.
  function automatic logic [W:0] model(bit am, logic [7:0] f, logic [7:0] s1, logic [7:0] s2,
                                       logic [1:0] cs, bit ci,
                                       logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
    logic [W-1:0] x, y;
    int inc;
    for (int i = 0; i < W; i++) begin
      int bc;
      bc = 2 * c[i] + b[i];
      if (am) begin
        x[i] = a[i] & s1[2*bc+1];
        y[i] = s2[2*bc+1];
      end else begin
        x[i] = f[2*bc + a[i]];
        y[i] = 1'b0;
      end
    end
    inc = (cs == 2'b01) ? 1 : (cs == 2'b10) ? int'(ci) : 0;
    return {1'b0, x} + {1'b0, y} + (W+1)'(inc);
  endfunction

  logic         m_valid = 1'b0;
  logic [W-1:0] m_res = '0;
  logic         m_co = 1'b0;
  string        m_tag = "R1";

  always @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0; m_res <= '0; m_co <= 1'b0;
    end else begin
      m_valid <= in_valid;
      m_tag   <= cur_tag;
      if (in_valid) begin
        logic [W:0] t;
        t = model(arith_mode, fn_code, sub1_code, sub2_code, carry_sel, carry_in, op_a, op_b, op_c);
        m_res <= t[W-1:0];
        m_co  <= t[W];
      end
    end
  end

  // Compare every clock, away from the active edge.
  always @(negedge clk) begin
    if (running) begin
      checks++;
      if (out_valid !== m_valid || result !== m_res || carry_out !== m_co) begin
        fails++;
        $display("FAIL %s: got v=%0b r=%h c=%0b expected v=%0b r=%h c=%0b",
                 m_tag, out_valid, result, carry_out, m_valid, m_res, m_co);
      end
    end
  end

  task automatic issue(string tag, bit v, bit am, logic [7:0] f, logic [7:0] s1, logic [7:0] s2,
                       logic [1:0] cs, bit ci, logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
    @(negedge clk);
    cur_tag = tag; in_valid = v; arith_mode = am; fn_code = f; sub1_code = s1;
    sub2_code = s2; carry_sel = cs; carry_in = ci; op_a = a; op_b = b; op_c = c;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  localparam logic [W-1:0] PA = 32'hF0F0_CCAA, PB = 32'hFF00_FF00, PC = 32'hFFFF_0000;

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (out_valid !== 1'b0 || result !== '0 || carry_out !== 1'b0) begin
      fails++;
      $display("FAIL R1: got v=%0b r=%h c=%0b expected 0 0 0", out_valid, result, carry_out);
    end
    running = 1'b1;

    // R2: each single-minterm code
    for (int k = 0; k < 8; k++)
      issue("R2", 1, 0, 8'(1 << k), 0, 0, 2'b00, 0, PA, PB, PC);
    idle();

    // R3: all 256 truth tables on pseudo-random operands
    for (int k = 0; k < 256; k++)
      issue("R3", 1, 0, 8'(k), 0, 0, 2'b00, 0, $urandom, $urandom, $urandom);
    idle();

    // R4: +1 wrap of all ones (both Boolean events in one cycle), and plain +1
    issue("R4", 1, 0, 8'hFF, 0, 0, 2'b01, 0, PA, PB, PC);
    issue("R4", 1, 0, 8'hAA, 0, 0, 2'b01, 1, PA, PB, PC);
    idle();

    // R5: carry-in select, reserved select, none with carry_in high
    issue("R5", 1, 0, 8'hFF, 0, 0, 2'b10, 1, PA, PB, PC);
    issue("R5", 1, 0, 8'hFF, 0, 0, 2'b10, 0, PA, PB, PC);
    issue("R5", 1, 0, 8'hFF, 0, 0, 2'b11, 1, PA, PB, PC);
    issue("R5", 1, 0, 8'h96, 0, 0, 2'b00, 1, PA, PB, PC);
    idle();

    // R6: arithmetic forms: B, ~B, C, all ones, A&B + C, A&C - B - 1 + 1
    issue("R6", 1, 1, 0, 8'h00, 8'hCC, 2'b00, 0, PA, PB, PC);
    issue("R6", 1, 1, 0, 8'h00, 8'h33, 2'b01, 0, PA, 32'd5, PC);
    issue("R6", 1, 1, 0, 8'hCC, 8'hF0, 2'b00, 0, PA, PB, PC);
    issue("R6", 1, 1, 0, 8'hF0, 8'h33, 2'b10, 1, PA, PB, PC);
    issue("R6", 1, 1, 0, 8'hFF, 8'hFF, 2'b00, 0, 32'h1234_5678, PB, PC);
    for (int k = 0; k < 40; k++)
      issue("R6", 1, 1, 0, 8'($urandom), 8'($urandom), 2'($urandom), 1'($urandom),
            $urandom, $urandom, $urandom);
    idle();

    // R7: carry out of the sum: ~0 + ~0, and 0x80000000 + 0x80000000
    issue("R7", 1, 1, 0, 8'hFF, 8'hFF, 2'b01, 0, '1, PB, PC);
    issue("R7", 1, 1, 0, 8'hCC, 8'hCC, 2'b00, 0, '1, 32'h8000_0000, PC);
    issue("R7", 1, 1, 0, 8'hCC, 8'h00, 2'b01, 0, '1, 32'hFFFF_FFFF, PC);
    idle();

    // R8: back-to-back strobes with mode changing, then gaps
    issue("R8", 1, 0, 8'hE8, 0, 0, 2'b00, 0, PA, PB, PC);
    issue("R8", 1, 1, 0, 8'hCC, 8'hF0, 2'b01, 0, PA, PB, PC);
    issue("R8", 1, 0, 8'h17, 0, 0, 2'b00, 0, PA, PB, PC);
    issue("R8", 0, 0, 8'h00, 0, 0, 2'b00, 0, 0, 0, 0);
    issue("R8", 1, 0, 8'h0F, 0, 0, 2'b00, 0, PA, PB, PC);
    idle();

    // R9: inputs wiggle with no strobe; outputs must hold
    issue("R9", 1, 0, 8'hFF, 0, 0, 2'b01, 0, PA, PB, PC);
    for (int k = 0; k < 6; k++)
      issue("R9", 0, 1'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 2'($urandom),
            1'($urandom), $urandom, $urandom, $urandom);
    idle();

    // Reset mid-stream returns to R1 state
    issue("R1", 1, 0, 8'hFF, 0, 0, 2'b00, 0, PA, PB, PC);
    idle();
    @(negedge clk);
    running = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    checks++;
    if (out_valid !== 1'b0 || result !== '0 || carry_out !== 1'b0) begin
      fails++;
      $display("FAIL R1: got v=%0b r=%h c=%0b expected 0 0 0 after reset", out_valid, result, carry_out);
    end
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule